// File: doc/BRIEF.md
# DMA Address and Count Register Unit

This unit holds the programming state of a single DMA channel: a 14-bit transfer count, an enable flag, a stored read/write flag, the memory-direction flag and a 22-bit word-aligned transfer address. The CPU loads all of these through register writes on a small internal bus. The count and its flags come from the data word. The address is taken from the register access's own address-bus bits, in two halves that a bus-address select bit chooses between.

Each cycle in which the DMA engine raises a request while the channel is enabled, the unit looks at the two page-state bits of the target page. A mapped page advances the address by one word and decrements the count. The channel disables itself when the count steps past zero. An unmapped page (both state bits zero) does not advance anything. Instead it loads a general status word and two bus status words that describe the faulting transfer, pulses a fault flag and raises a level-7 interrupt request. That request stays high until software writes the clear-status register. The data path of the transfer lies outside this unit.

Top module: `dma_regs_unit`

## Requirements
- R1: After reset, the general status, bus status 0 and bus status 1 registers read 0xFFFF, the count register reads 0xC000, dma_addr is 0, and dma_active, dma_fault and irq_l7 are 0.
- R2: A write to register id 0 (count) stores wdata[13:0]+1 modulo 2^14 as the count, wdata[14] as dma_rw_flag and wdata[15] as dma_active. A read of id 0 returns the count in bits [13:0] with bits [15:14] set to 1.
- R3: A write to register id 1 (address) with bus_addr[14]=1 loads dma_addr[21:9] from bus_addr[13:1] and keeps dma_addr[8:1].
- R4: A write to id 1 with bus_addr[14]=0 loads dma_addr[8:1] from bus_addr[8:1] and keeps dma_addr[21:9]. dma_addr[0] is always 0.
- R5: A dma_req cycle with dma_active=1 and page_ps not 00 adds 2 to dma_addr, subtracts 1 from the count, and leaves dma_fault low.
- R6: A mapped DMA cycle taken while the count is 0 wraps the count to 0x3FFF and clears dma_active. dma_req has no effect while dma_active is 0.
- R7: A dma_req cycle with dma_active=1 and page_ps=00 leaves dma_addr and the count unchanged and loads the general status (id 5) with 0xABFF, ORed with 0x4000 when the memory-read flag is set and with 0x0400 when the parity-interrupt flag is set.
- R8: On that fault, bus status 0 (id 6) becomes 0x3C00 ORed with dma_addr[21:16], and bus status 1 (id 7) becomes dma_addr[15:0].
- R9: A fault raises dma_fault for exactly the following cycle and sets irq_l7. irq_l7 stays set until a write to id 3 (clear status), which drops it and sets all three status registers to 0xFFFF.
- R10: In a cycle with reg_wr high, dma_req is ignored. No step and no fault happen in that cycle.
- R11: The memory-read flag is wdata[14] of a write to id 2 (misc control). The parity-interrupt flag is wdata[15] of a write to id 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_id | input | 3 | Register select: 0 count, 1 address, 2 misc, 3 clear, 4 parity enable, 5 general status, 6 bus status 0, 7 bus status 1 |
| bus_addr | input | 14 | Address-bus bits [14:1] of the register access |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid the cycle after the read strobe |
| dma_req | input | 1 | DMA engine requests a transfer cycle |
| page_ps | input | 2 | Page-state bits of the target page (00 = unmapped) |
| dma_addr | output | 22 | Current DMA byte address |
| dma_active | output | 1 | Channel enable flag |
| dma_rw_flag | output | 1 | Stored read/write flag from the count write |
| dma_fault | output | 1 | One-cycle pulse after an unmapped DMA cycle |
| irq_l7 | output | 1 | Level-7 interrupt request, held until cleared |

## Verification
Every result lands one clock edge after its stimulus. Register writes, DMA steps and faults change dma_addr, dma_active, dma_fault and irq_l7 at the edge that samples the strobe. Read data is registered at the edge that samples reg_rd. The bench's driver tasks raise a strobe for exactly one cycle and push the expected value onto a scoreboard queue at the following falling edge. The monitor pops and compares shortly after that falling edge, so each comparison lands mid-cycle, one edge after the stimulus, and away from any active edge.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

    typedef enum logic [2:0] {
        RID_COUNT = 3'd0,
        RID_ADDR  = 3'd1,
        RID_MISC  = 3'd2,
        RID_CLEAR = 3'd3,
        RID_PIE   = 3'd4,
        RID_GSTAT = 3'd5,
        RID_BSR0  = 3'd6,
        RID_BSR1  = 3'd7
    } reg_id_e;

    localparam int STAT_W = 16;

    localparam logic [STAT_W-1:0] STAT_IDLE       = 16'hFFFF;
    localparam logic [STAT_W-1:0] GSTAT_DMA_FAULT = 16'hABFF;
    localparam logic [STAT_W-1:0] GSTAT_READ_BIT  = 16'h4000;
    localparam logic [STAT_W-1:0] GSTAT_PIE_BIT   = 16'h0400;
    localparam logic [STAT_W-1:0] BSR0_DMA_TAG    = 16'h3C00;

endpackage

// File: rtl/dma_addr_reg.sv
module dma_addr_reg #(
    parameter int ADDR_W = 22,
    parameter int LO_W   = 8,
    localparam int HI_W  = ADDR_W - LO_W - 1,
    localparam int BUS_W = HI_W + 2,
    localparam int WRD_W = ADDR_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BUS_W-1:1]  bus_addr,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [WRD_W-1:0] WORD_ONE = WRD_W'(1);

    logic [WRD_W-1:0] word_d;
    logic [WRD_W-1:0] word_q;

    always_comb begin
        word_d = word_q;
        if (load) begin
            if (bus_addr[BUS_W-1]) begin
                word_d[WRD_W-1:LO_W] = bus_addr[HI_W:1];
            end else begin
                word_d[LO_W-1:0] = bus_addr[LO_W:1];
            end
        end else if (step) begin
            word_d = word_q + WORD_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    assign addr = {word_q, 1'b0};

endmodule

// File: rtl/dma_count_reg.sv
module dma_count_reg #(
    parameter int CNT_W  = 14,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata,
    input  logic              step,
    output logic [CNT_W-1:0]  count,
    output logic              enable,
    output logic              rw_flag
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             en;
        logic             rw;
    } cnt_state_t;

    cnt_state_t st_d;
    cnt_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt = wdata[CNT_W-1:0] + CNT_ONE;
            st_d.rw  = wdata[DATA_W-2];
            st_d.en  = wdata[DATA_W-1];
        end else if (step) begin
            st_d.cnt = st_q.cnt - CNT_ONE;
            if (st_q.cnt == '0) begin
                st_d.en = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count   = st_q.cnt;
    assign enable  = st_q.en;
    assign rw_flag = st_q.rw;

endmodule

// File: rtl/dma_fault_gen.sv
module dma_fault_gen
    import dma_regs_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic              clr,
    input  logic              reading,
    input  logic              pie,
    input  logic [ADDR_W-1:0] addr,
    output logic [STAT_W-1:0] gstat,
    output logic [STAT_W-1:0] bsr0,
    output logic [STAT_W-1:0] bsr1,
    output logic              irq,
    output logic              fault
);

    localparam int UP_W = ADDR_W - STAT_W;

    typedef struct packed {
        logic [STAT_W-1:0] gstat;
        logic [STAT_W-1:0] bsr0;
        logic [STAT_W-1:0] bsr1;
        logic              irq;
        logic              flt;
    } flt_state_t;

    flt_state_t st_d;
    flt_state_t st_q;

    always_comb begin
        st_d     = st_q;
        st_d.flt = 1'b0;
        if (clr) begin
            st_d.gstat = STAT_IDLE;
            st_d.bsr0  = STAT_IDLE;
            st_d.bsr1  = STAT_IDLE;
            st_d.irq   = 1'b0;
        end else if (hit) begin
            st_d.gstat = GSTAT_DMA_FAULT
                       | (reading ? GSTAT_READ_BIT : '0)
                       | (pie     ? GSTAT_PIE_BIT  : '0);
            st_d.bsr0  = BSR0_DMA_TAG
                       | {{(STAT_W-UP_W){1'b0}}, addr[ADDR_W-1:STAT_W]};
            st_d.bsr1  = addr[STAT_W-1:0];
            st_d.irq   = 1'b1;
            st_d.flt   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.gstat <= STAT_IDLE;
            st_q.bsr0  <= STAT_IDLE;
            st_q.bsr1  <= STAT_IDLE;
            st_q.irq   <= 1'b0;
            st_q.flt   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gstat = st_q.gstat;
    assign bsr0  = st_q.bsr0;
    assign bsr1  = st_q.bsr1;
    assign irq   = st_q.irq;
    assign fault = st_q.flt;

endmodule

// File: rtl/dma_regs_unit.sv
module dma_regs_unit
    import dma_regs_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int CNT_W  = 14,
    parameter int DATA_W = 16,
    parameter int LO_W   = 8,
    localparam int HI_W  = ADDR_W - LO_W - 1,
    localparam int BUS_W = HI_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_id,
    input  logic [BUS_W-1:1]  bus_addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              dma_req,
    input  logic [1:0]        page_ps,
    output logic [ADDR_W-1:0] dma_addr,
    output logic              dma_active,
    output logic              dma_rw_flag,
    output logic              dma_fault,
    output logic              irq_l7
);

    typedef struct packed {
        logic              reading;
        logic              pie;
        logic [DATA_W-1:0] rdata;
    } ctl_state_t;

    ctl_state_t ctl_d;
    ctl_state_t ctl_q;

    reg_id_e           rid;
    logic              dma_go;
    logic              page_unmapped;
    logic              step_ok;
    logic              fault_hit;
    logic              clr_wr;
    logic [CNT_W-1:0]  count;
    logic [STAT_W-1:0] gstat;
    logic [STAT_W-1:0] bsr0;
    logic [STAT_W-1:0] bsr1;

    assign rid           = reg_id_e'(reg_id);
    assign dma_go        = dma_req && dma_active && !reg_wr;
    assign page_unmapped = (page_ps == 2'b00);
    assign step_ok       = dma_go && !page_unmapped;
    assign fault_hit     = dma_go && page_unmapped;
    assign clr_wr        = reg_wr && (rid == RID_CLEAR);

    dma_addr_reg #(
        .ADDR_W (ADDR_W),
        .LO_W   (LO_W)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (reg_wr && (rid == RID_ADDR)),
        .bus_addr (bus_addr),
        .step     (step_ok),
        .addr     (dma_addr)
    );

    dma_count_reg #(
        .CNT_W  (CNT_W),
        .DATA_W (DATA_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (reg_wr && (rid == RID_COUNT)),
        .wdata   (wdata),
        .step    (step_ok),
        .count   (count),
        .enable  (dma_active),
        .rw_flag (dma_rw_flag)
    );

    dma_fault_gen #(
        .ADDR_W (ADDR_W)
    ) u_flt (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (fault_hit),
        .clr     (clr_wr),
        .reading (ctl_q.reading),
        .pie     (ctl_q.pie),
        .addr    (dma_addr),
        .gstat   (gstat),
        .bsr0    (bsr0),
        .bsr1    (bsr1),
        .irq     (irq_l7),
        .fault   (dma_fault)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (reg_wr && (rid == RID_MISC)) begin
            ctl_d.reading = wdata[DATA_W-2];
        end
        if (reg_wr && (rid == RID_PIE)) begin
            ctl_d.pie = wdata[DATA_W-1];
        end
        if (reg_rd) begin
            case (rid)
                RID_COUNT: ctl_d.rdata = {{(DATA_W-CNT_W){1'b1}}, count};
                RID_GSTAT: ctl_d.rdata = gstat;
                RID_BSR0:  ctl_d.rdata = bsr0;
                RID_BSR1:  ctl_d.rdata = bsr1;
                default:   ctl_d.rdata = '1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.reading <= 1'b0;
            ctl_q.pie     <= 1'b0;
            ctl_q.rdata   <= '1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rdata = ctl_q.rdata;

endmodule

// File: rtl/dma_regs_unit_chk.sv
module dma_regs_unit_chk
    import dma_regs_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [2:0]        reg_id,
    input logic              dma_req,
    input logic [1:0]        page_ps,
    input logic [ADDR_W-1:0] dma_addr,
    input logic              dma_active,
    input logic              dma_fault,
    input logic              irq_l7
);

    localparam logic [ADDR_W-1:0] ADDR_TWO = ADDR_W'(2);

    AST_ADDR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        dma_addr[0] == 1'b0); // R4

    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && dma_active && page_ps != 2'b00 && !reg_wr)
        |=> (dma_addr == $past(dma_addr) + ADDR_TWO) && !dma_fault); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_active && !reg_wr) |=> $stable(dma_addr)); // R6

    AST_FAULT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && dma_active && page_ps == 2'b00 && !reg_wr)
        |=> $stable(dma_addr) && dma_fault); // R7

    AST_FAULT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        dma_fault |-> irq_l7); // R9

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_l7 && !(reg_wr && reg_id == RID_CLEAR)) |=> irq_l7); // R9

    AST_CLEAR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_id == RID_CLEAR) |=> !irq_l7); // R9

    AST_WR_BLOCKS_DMA: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !dma_fault); // R10

endmodule

bind dma_regs_unit dma_regs_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_id     (reg_id),
    .dma_req    (dma_req),
    .page_ps    (page_ps),
    .dma_addr   (dma_addr),
    .dma_active (dma_active),
    .dma_fault  (dma_fault),
    .irq_l7     (irq_l7)
);

// File: tb/dma_regs_unit_bench.sv
module dma_regs_unit_bench;

    localparam int CLK_PERIOD = 10;

    localparam int K_RDATA  = 0;
    localparam int K_ADDR   = 1;
    localparam int K_IRQ    = 2;
    localparam int K_FAULT  = 3;
    localparam int K_ACTIVE = 4;
    localparam int K_RWFLAG = 5;

    localparam logic [2:0] ID_COUNT = 3'd0;
    localparam logic [2:0] ID_ADDR  = 3'd1;
    localparam logic [2:0] ID_MISC  = 3'd2;
    localparam logic [2:0] ID_CLEAR = 3'd3;
    localparam logic [2:0] ID_PIE   = 3'd4;
    localparam logic [2:0] ID_GSTAT = 3'd5;
    localparam logic [2:0] ID_BSR0  = 3'd6;
    localparam logic [2:0] ID_BSR1  = 3'd7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_id = 3'd0;
    logic [14:1] bus_addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        dma_req = 1'b0;
    logic [1:0]  page_ps = 2'b00;
    logic [21:0] dma_addr;
    logic        dma_active;
    logic        dma_rw_flag;
    logic        dma_fault;
    logic        irq_l7;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    int          q_kind[$];
    logic [31:0] q_exp[$];
    string       q_req[$];

    logic [21:0] exp_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_regs_unit u_dma_regs_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_rd      (reg_rd),
        .reg_id      (reg_id),
        .bus_addr    (bus_addr),
        .wdata       (wdata),
        .rdata       (rdata),
        .dma_req     (dma_req),
        .page_ps     (page_ps),
        .dma_addr    (dma_addr),
        .dma_active  (dma_active),
        .dma_rw_flag (dma_rw_flag),
        .dma_fault   (dma_fault),
        .irq_l7      (irq_l7)
    );

    task automatic push(input int k, input logic [31:0] e, input string r);
        q_kind.push_back(k);
        q_exp.push_back(e);
        q_req.push_back(r);
    endtask

    task automatic wr(input logic [2:0] id, input logic [14:1] ba, input logic [15:0] d);
        reg_wr   = 1'b1;
        reg_id   = id;
        bus_addr = ba;
        wdata    = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] id, input logic [15:0] e, input string r);
        reg_rd = 1'b1;
        reg_id = id;
        @(negedge clk);
        reg_rd = 1'b0;
        push(K_RDATA, {16'h0, e}, r);
    endtask

    task automatic dma(input logic [1:0] ps);
        dma_req = 1'b1;
        page_ps = ps;
        @(negedge clk);
        dma_req = 1'b0;
    endtask

    // Monitor: compares queued expectations a little after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q_kind.size() > 0) begin
                int          k;
                logic [31:0] e;
                logic [31:0] a;
                string       r;
                k = q_kind.pop_front();
                e = q_exp.pop_front();
                r = q_req.pop_front();
                case (k)
                    K_RDATA:  a = {16'h0, rdata};
                    K_ADDR:   a = {10'h0, dma_addr};
                    K_IRQ:    a = {31'h0, irq_l7};
                    K_FAULT:  a = {31'h0, dma_fault};
                    K_ACTIVE: a = {31'h0, dma_active};
                    default:  a = {31'h0, dma_rw_flag};
                endcase
                n_checks++;
                if (a !== e) begin
                    n_fails++;
                    $display("FAIL %s: kind %0d actual=%h expected=%h", r, k, a, e);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        exp_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        push(K_ADDR, 32'h0, "R1");
        push(K_ACTIVE, 32'h0, "R1");
        push(K_IRQ, 32'h0, "R1");
        push(K_FAULT, 32'h0, "R1");
        rd(ID_GSTAT, 16'hFFFF, "R1");
        rd(ID_BSR0, 16'hFFFF, "R1");
        rd(ID_BSR1, 16'hFFFF, "R1");
        rd(ID_COUNT, 16'hC000, "R1");

        // R6 request ignored while disabled
        dma(2'b10);
        push(K_ADDR, 32'h0, "R6");

        // R2 count load: 0x3FFF + 1 wraps to 0, rw flag set, enable clear
        wr(ID_COUNT, '0, 16'h7FFF);
        push(K_RWFLAG, 32'h1, "R2");
        push(K_ACTIVE, 32'h0, "R2");
        rd(ID_COUNT, 16'hC000, "R2");
        wr(ID_COUNT, '0, 16'h8005);
        push(K_RWFLAG, 32'h0, "R2");
        push(K_ACTIVE, 32'h1, "R2");
        rd(ID_COUNT, 16'hC006, "R2");

        // R3 / R4 address loads from bus address bits
        wr(ID_ADDR, {1'b1, 13'h1ABC}, '0);
        exp_addr = {13'h1ABC, 8'h00, 1'b0};
        push(K_ADDR, {10'h0, exp_addr}, "R3");
        wr(ID_ADDR, {1'b0, 5'h1F, 8'hA5}, '0);
        exp_addr = {13'h1ABC, 8'hA5, 1'b0};
        push(K_ADDR, {10'h0, exp_addr}, "R4");
        wr(ID_ADDR, {1'b1, 13'h0123}, '0);
        exp_addr = {13'h0123, 8'hA5, 1'b0};
        push(K_ADDR, {10'h0, exp_addr}, "R3");
        wr(ID_ADDR, {1'b1, 13'h1ABC}, '0);
        exp_addr = {13'h1ABC, 8'hA5, 1'b0};
        push(K_ADDR, {10'h0, exp_addr}, "R4");

        // R5 / R6 stepping: count 2 gives three steps then disable
        wr(ID_COUNT, '0, 16'h8001);
        dma(2'b10);
        exp_addr = exp_addr + 22'd2;
        push(K_ADDR, {10'h0, exp_addr}, "R5");
        push(K_FAULT, 32'h0, "R5");
        push(K_ACTIVE, 32'h1, "R5");
        rd(ID_COUNT, 16'hC001, "R5");
        dma(2'b11);
        exp_addr = exp_addr + 22'd2;
        push(K_ADDR, {10'h0, exp_addr}, "R5");
        push(K_ACTIVE, 32'h1, "R5");
        dma(2'b10);
        exp_addr = exp_addr + 22'd2;
        push(K_ADDR, {10'h0, exp_addr}, "R6");
        push(K_ACTIVE, 32'h0, "R6");
        dma(2'b10);
        push(K_ADDR, {10'h0, exp_addr}, "R6");
        rd(ID_COUNT, 16'hFFFF, "R6");

        // R7 / R8 / R9 / R11 fault with read direction and parity enable
        wr(ID_PIE, '0, 16'h8000);
        wr(ID_MISC, '0, 16'h4000);
        wr(ID_COUNT, '0, 16'h8003);
        dma(2'b00);
        push(K_FAULT, 32'h1, "R9");
        push(K_IRQ, 32'h1, "R9");
        push(K_ADDR, {10'h0, exp_addr}, "R7");
        rd(ID_GSTAT, 16'hEFFF, "R7");
        push(K_FAULT, 32'h0, "R9");
        rd(ID_BSR0, 16'h3C00 | {10'h0, exp_addr[21:16]}, "R8");
        rd(ID_BSR1, exp_addr[15:0], "R8");
        rd(ID_COUNT, 16'hC004, "R7");
        push(K_IRQ, 32'h1, "R9");

        // R9 clear status
        wr(ID_CLEAR, '0, '0);
        push(K_IRQ, 32'h0, "R9");
        rd(ID_GSTAT, 16'hFFFF, "R9");
        rd(ID_BSR1, 16'hFFFF, "R9");

        // R11 flags cleared, mapped state 01, then plain fault word
        wr(ID_PIE, '0, 16'h0000);
        wr(ID_MISC, '0, 16'h0000);
        dma(2'b01);
        exp_addr = exp_addr + 22'd2;
        push(K_ADDR, {10'h0, exp_addr}, "R5");
        dma(2'b00);
        rd(ID_GSTAT, 16'hABFF, "R11");
        rd(ID_BSR1, exp_addr[15:0], "R8");
        wr(ID_CLEAR, '0, '0);

        // R10 register write owns the cycle
        reg_wr   = 1'b1;
        reg_id   = ID_ADDR;
        bus_addr = {1'b0, 5'h00, 8'h10};
        dma_req  = 1'b1;
        page_ps  = 2'b00;
        @(negedge clk);
        reg_wr  = 1'b0;
        dma_req = 1'b0;
        exp_addr = {exp_addr[21:9], 8'h10, 1'b0};
        push(K_FAULT, 32'h0, "R10");
        push(K_IRQ, 32'h0, "R10");
        push(K_ADDR, {10'h0, exp_addr}, "R10");
        reg_wr   = 1'b1;
        reg_id   = ID_ADDR;
        bus_addr = {1'b0, 5'h00, 8'h20};
        dma_req  = 1'b1;
        page_ps  = 2'b10;
        @(negedge clk);
        reg_wr  = 1'b0;
        dma_req = 1'b0;
        exp_addr = {exp_addr[21:9], 8'h20, 1'b0};
        push(K_ADDR, {10'h0, exp_addr}, "R10");
        rd(ID_COUNT, 16'hC003, "R10");

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule